// File: doc/BRIEF.md
# Serial Port Interrupt Collector with Keyed Core Reset

This block sits beside a serial peripheral engine and turns its single-cycle or level event lines into sticky interrupt flags. Each flag is qualified by its own enable bit, and the qualified flags are combined and then gated by one master enable bit to form a single interrupt line. Software clears a flag by writing a one to its position. The usual handler reads the flag register and writes the same value back, which clears exactly the flags it saw.

A separate reset register lets software restart the attached engine. The restart happens only when one fixed key value is written. The key write drives a reset strobe of fixed length to the engine. It also returns the flag, enable and master-enable registers of this block to zero.

The register interface is a simple single-cycle write strobe with an address and data. Read data is a combinational function of the address.

Top module: `spi_irq_agg`

## Requirements
- R1: After synchronous reset, `irq_o` and `core_rst_o` are low, and every register reads back as zero.
- R2: Flag bit i sets on the clock edge where `evt_i[i]` is high and was low at the previous edge. The flag sets whatever its enable bit holds. The bit order is: 0 mode fault, 1 slave mode fault, 2 transmit queue empty, 3 transmit underrun, 4 receive queue full, 5 receive overrun, 6 transmit queue half empty. A level that is already high when reset is released does not count as a rising edge. A level that is held high does not set the flag again.
- R3: A write to address 0x20 clears every flag whose data bit is 1 and leaves the others unchanged. A read returns the flags in bits 6:0 with zeros above.
- R4: When a rising edge and a clear reach the same flag in the same cycle, the flag stays set.
- R5: The enable register at address 0x28 stores and returns data bits 6:0. Bits above 6 read as zero.
- R6: The master-enable register at address 0x1C stores data bit 31 only. It reads back as that bit in position 31, with zeros elsewhere.
- R7: `irq_o` is high exactly when the master enable is set and at least one flag is set whose enable bit is also set. It reflects register values that were updated at the previous edge.
- R8: A write of 0x0A to address 0x40 raises `core_rst_o` for exactly 16 cycles, starting after that edge. The same write clears the flag, enable and master-enable registers. Events in that same cycle are dropped.
- R9: A write of any other value to address 0x40 changes neither `core_rst_o` nor any register.
- R10: A key write made while the strobe is high restarts the 16-cycle count.
- R11: Address 0x40 and unmapped addresses read as zero. Writes to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | Event lines from the serial engine |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |
| core_rst_o | output | 1 | Reset strobe to the serial engine |

## Verification
Directed sequences cover the cases that random stimulus rarely lines up:
- an event line held high through reset, which separates edge detection from level sampling;
- a clear that lands in the same cycle as a rising edge, which shows the priority between them;
- a wrong key value, which must leave the strobe low;
- a second key write in mid-strobe, which shows whether the counter reloads or just runs out.

A long random phase then mixes toggling event lines with writes to every register and to unmapped space, and a rare key write. It compares the interrupt line, the strobe and a read of a random address against a reference model on every cycle. This separates faults in masking from faults in gating by the master enable or in clearing.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int N_SRC   = 7;
    localparam int RST_LEN = 16;

    localparam logic [ADDR_W-1:0] A_GIE  = 8'h1C;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h20;
    localparam logic [ADDR_W-1:0] A_EN   = 8'h28;
    localparam logic [ADDR_W-1:0] A_SRST = 8'h40;

    localparam logic [DATA_W-1:0] SRST_KEY = 32'h0000_000A;
    localparam int GIE_BIT = 31;

    // Event source positions (bit index in the flag register)
    typedef enum logic [2:0] {
        SRC_MODE_FLT   = 3'd0,
        SRC_SLV_FLT    = 3'd1,
        SRC_TX_EMPTY   = 3'd2,
        SRC_TX_UNDER   = 3'd3,
        SRC_RX_FULL    = 3'd4,
        SRC_RX_OVER    = 3'd5,
        SRC_TX_HALF    = 3'd6
    } src_e;

    typedef struct packed {
        logic gie_we;
        logic stat_we;
        logic en_we;
        logic key_hit;   // write to reset register with the correct key
        logic key_miss;  // write to reset register with any other value
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(input logic wr,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic [DATA_W-1:0] data);
        wr_dec_t d;
        d.gie_we   = wr && (addr == A_GIE);
        d.stat_we  = wr && (addr == A_STAT);
        d.en_we    = wr && (addr == A_EN);
        d.key_hit  = wr && (addr == A_SRST) && (data == SRST_KEY);
        d.key_miss = wr && (addr == A_SRST) && (data != SRST_KEY);
        return d;
    endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic         wipe,
    output logic [N-1:0] status_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;
    logic [N-1:0] status_q;

    // A line high at reset release is treated as already seen
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= evt_i;
    end

    assign rise = evt_i & ~prev_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst || wipe)
                    status_q[i] <= 1'b0;
                else if (rise[i])
                    status_q[i] <= 1'b1;
                else if (clr_we && clr_mask[i])
                    status_q[i] <= 1'b0;
            end
        end
    endgenerate

    assign status_o = status_q;

    // R2
    rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (rise != '0 && !wipe) |=> ((status_q & $past(rise)) == $past(rise)));
    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_we && !wipe) |=> ((status_q & $past(status_q)) == $past(status_q)));
    // R8
    wipe_clears_chk: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (status_q == '0));

endmodule

// File: rtl/srst_pulse.sv
module srst_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse_o
);
    localparam int CNT_W = $clog2(LEN + 1);
    localparam logic [CNT_W-1:0] LEN_C = CNT_W'(LEN);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (fire)
            cnt_q <= LEN_C;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign pulse_o = (cnt_q != '0);

    // R10
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt_q == LEN_C));
    // R8
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (!fire && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R8
    start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $past(fire));

endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
    import spi_irq_pkg::*;
#(
    parameter int NSRC = N_SRC,
    parameter int RLEN = RST_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              core_rst_o
);
    localparam int PAD = DATA_W - NSRC;

    wr_dec_t          dec;
    logic [NSRC-1:0]  status;
    logic [NSRC-1:0]  en_q;
    logic             gie_q;

    assign dec = decode_wr(bus_wr, bus_addr, bus_wdata);

    irq_src_latch #(.N(NSRC)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_i),
        .clr_we   (dec.stat_we),
        .clr_mask (bus_wdata[NSRC-1:0]),
        .wipe     (dec.key_hit),
        .status_o (status)
    );

    srst_pulse #(.LEN(RLEN)) u_srst (
        .clk     (clk),
        .rst     (rst),
        .fire    (dec.key_hit),
        .pulse_o (core_rst_o)
    );

    always_ff @(posedge clk) begin
        if (rst || dec.key_hit) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else begin
            if (dec.en_we)  en_q  <= bus_wdata[NSRC-1:0];
            if (dec.gie_we) gie_q <= bus_wdata[GIE_BIT];
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_GIE:   bus_rdata = {gie_q, {(DATA_W-1){1'b0}}};
            A_STAT:  bus_rdata = {{PAD{1'b0}}, status};
            A_EN:    bus_rdata = {{PAD{1'b0}}, en_q};
            default: bus_rdata = '0;
        endcase
    end

    assign irq_o = gie_q && ((status & en_q) != '0);

    // R7
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> gie_q);
    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> !irq_o);
    // R9
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.key_miss && !core_rst_o) |=> !core_rst_o);
    // R6
    gie_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!dec.gie_we && !dec.key_hit) |=> $stable(gie_q));

endmodule

// File: tb/sim_spi_irq_agg.sv
module sim_spi_irq_agg;
    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  evt;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        core_rst_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    logic [6:0] m_stat, m_en, m_prev;
    logic       m_gie;
    int         m_cnt;

    always #5 clk = ~clk;

    spi_irq_agg u0 (
        .clk(clk), .rst(rst), .evt_i(evt), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .core_rst_o(core_rst_o)
    );

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        case (a)
            8'h1C:   return {m_gie, 31'b0};
            8'h20:   return {25'b0, m_stat};
            8'h28:   return {25'b0, m_en};
            default: return 32'b0;
        endcase
    endfunction

    task automatic model_update(input logic w, input logic [7:0] a,
                                input logic [31:0] d, input logic [6:0] e);
        logic [6:0] rise;
        rise   = e & ~m_prev;
        m_prev = e;
        if (w && a == 8'h40 && d == 32'h0A) begin
            m_stat = '0; m_en = '0; m_gie = 1'b0; m_cnt = 16;
        end else begin
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (w && a == 8'h20) m_stat = m_stat & ~d[6:0];
            m_stat = m_stat | rise;
            if (w && a == 8'h28) m_en = d[6:0];
            if (w && a == 8'h1C) m_gie = d[31];
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic [6:0] e, input logic [7:0] ra);
        bus_wr = w; bus_addr = a; bus_wdata = d; evt = e;
        @(posedge clk);
        model_update(w, a, d, e);
        @(negedge clk);
        check(tag, "irq_o", {31'b0, irq_o}, {31'b0, m_gie && ((m_stat & m_en) != 0)});
        check(tag, "core_rst_o", {31'b0, core_rst_o}, {31'b0, m_cnt > 0});
        bus_wr = 1'b0; bus_addr = ra;
        #1;
        check(tag, "bus_rdata", bus_rdata, model_rd(ra));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [6:0] e;
        void'($urandom(32'd2024));
        rst = 1'b1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; evt = 7'h04;
        repeat (3) @(posedge clk);
        m_stat = 0; m_en = 0; m_gie = 0; m_prev = '1; m_cnt = 0;
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state, R2 level held through reset is not an edge
        check("R1", "irq_o", {31'b0, irq_o}, 32'b0);
        check("R1", "core_rst_o", {31'b0, core_rst_o}, 32'b0);
        step("R2", 0, 8'h00, 0, 7'h04, 8'h20);
        step("R1", 0, 8'h00, 0, 7'h04, 8'h28);
        step("R1", 0, 8'h00, 0, 7'h04, 8'h1C);
        // R5 enable register, R6 master enable
        step("R5", 1, 8'h28, 32'hFFFF_FF7F, 7'h04, 8'h28);
        step("R6", 1, 8'h1C, 32'hFFFF_FFFF, 7'h04, 8'h1C);
        // R2/R7 rising edge on bit 0 raises irq
        step("R7", 0, 8'h00, 0, 7'h05, 8'h20);
        // R3 write-back clear while level still high: no re-set
        step("R3", 1, 8'h20, 32'h01, 7'h05, 8'h20);
        step("R3", 0, 8'h00, 0, 7'h00, 8'h20);
        // R4 event and clear on bit 1 in same cycle
        step("R4", 1, 8'h20, 32'h02, 7'h02, 8'h20);
        // R7 master enable off
        step("R7", 1, 8'h1C, 32'h7FFF_FFFF, 7'h02, 8'h1C);
        step("R7", 1, 8'h1C, 32'h8000_0000, 7'h02, 8'h1C);
        // R9 wrong key
        step("R9", 1, 8'h40, 32'h0B, 7'h02, 8'h28);
        step("R9", 1, 8'h40, 32'h10A, 7'h02, 8'h20);
        // R11 unmapped and reset register reads
        step("R11", 1, 8'h30, 32'hFFFF_FFFF, 7'h02, 8'h30);
        step("R11", 0, 8'h00, 0, 7'h02, 8'h40);
        // R8 key write, R10 restart mid-strobe
        step("R8", 1, 8'h40, 32'h0A, 7'h03, 8'h20);
        for (int i = 0; i < 8; i++) step("R8", 0, 8'h00, 0, 7'h03, 8'h28);
        step("R10", 1, 8'h40, 32'h0A, 7'h03, 8'h1C);
        for (int i = 0; i < 20; i++) step("R10", 0, 8'h00, 0, 7'h03, 8'h20);
        // random phase
        e = 7'h03;
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        w;
            int          sel;
            sel = $urandom_range(0, 19);
            case (sel)
                0, 1, 2, 3, 4: a = 8'h20;
                5, 6, 7:       a = 8'h28;
                8, 9:          a = 8'h1C;
                10:            a = 8'h40;
                11:            a = 8'h34;
                default:       a = 8'h00;
            endcase
            d = $urandom;
            if (a == 8'h40 && ($urandom_range(0, 3) == 0)) d = 32'h0A;
            w = (sel <= 11);
            e = e ^ 7'($urandom & $urandom & $urandom);
            case ($urandom_range(0, 3))
                0: step("R7", w, a, d, e, 8'h20);
                1: step("R5", w, a, d, e, 8'h28);
                2: step("R6", w, a, d, e, 8'h1C);
                default: step("R3", w, a, d, e, 8'h20);
            endcase
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule